// File: doc/BRIEF.md
# Pipelined Look-Ahead Binary Counter

This block is a wide synchronous up-counter whose clock period does not grow with its width. The count is split into a low-order stage of `LOW_W` bits and a row of 2-bit upper stages. No carry ripples through the stages. A look-ahead path watches the low stage and registers a flag one enabled cycle before the low stage wraps. A second registered chain records, for each upper stage, whether every upper stage below it is full. On any edge, an upper stage advances only through one AND of the enable, the registered low-stage flag and its own registered chain bit.

The output is the plain binary count, readable in every cycle with no decoding. It moves by one on the same edge that samples the enable, with no extra latency. Typical uses are clock division and event timing, where the counter must keep up with a fast clock whatever its width.

Top module: `ppc_counter`

## Requirements
- R1: A synchronous reset sets `count` to zero and clears the look-ahead flags. The first enabled edge after reset produces a count of 1.
- R2: Each rising edge with `en` high and `rst` low increases `count` by exactly one. The new value is visible right after that edge.
- R3: A rising edge with `en` low and `rst` low leaves `count` unchanged.
- R4: From the all-ones value, an enabled edge gives zero.
- R5: An upper 2-bit stage advances only on an enabled edge where all bits below it are ones. For example, 0x000F goes to 0x0010 and 0x00FF goes to 0x0100.
- R6: The registered early-overflow flag is high exactly when the low stage holds all ones. This holds on every edge out of reset.
- R7: `count` is `LOW_W + 2*PAIRS` bits wide. Bit 0 is the LSB of the low stage, and upper stage k occupies bits `LOW_W+2k` and `LOW_W+2k+1`.
- R8: Pauses in `en` of any length, including a pause while the low stage holds all ones, do not lose or duplicate a carry. Counting resumes with the correct next value.
- R9: When `rst` and `en` are both high on the same edge, the reset wins and `count` becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| count | output | LOW_W+2*PAIRS | Binary count value |

## Verification
Two things can fall on the same edge. One is the low stage wrapping while upper stages advance. The other is a synchronous reset while the enable is high. The bench provokes the first by running straight through the 0x000F, 0x00FF and full 0xFFFF boundaries, and also by holding the enable low at the moment the low stage reads all ones before resuming. It provokes the second by asserting reset with the enable still high in the middle of a run. Both are judged against an independent reference count that increments on every enabled edge and clears on reset.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int PAIR_W = 2;

  // next value of a 2-bit upper stage
  function automatic logic [PAIR_W-1:0] fn_pair_next(input logic [PAIR_W-1:0] v,
                                                     input logic adv);
    return adv ? v + 1'b1 : v;
  endfunction

  // width of the whole count
  function automatic int fn_total_width(input int low_w, input int pairs);
    return low_w + PAIR_W * pairs;
  endfunction
endpackage

// File: rtl/ppc_low_stage.sv
module ppc_low_stage #(
  parameter int LOW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [LOW_W-1:0] low_q,
  output logic             eo_q
);
  // value one step before the low stage wraps
  localparam logic [LOW_W-1:0] PRE_WRAP = {{(LOW_W-1){1'b1}}, 1'b0};

  logic pre_wrap_hit;
  assign pre_wrap_hit = (low_q == PRE_WRAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= '0;
      eo_q  <= 1'b0;
    end else if (en) begin
      low_q <= low_q + 1'b1;
      eo_q  <= pre_wrap_hit;
    end
  end
endmodule

// File: rtl/ppc_pair_stage.sv
module ppc_pair_stage
  import ppc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [PAIR_W-1:0] val_q,
  output logic              full_next
);
  logic [PAIR_W-1:0] val_d;
  assign val_d     = fn_pair_next(val_q, adv);
  assign full_next = &val_d;

  always_ff @(posedge clk) begin
    if (rst) val_q <= '0;
    else     val_q <= val_d;
  end
endmodule

// File: rtl/ppc_counter.sv
module ppc_counter
  import ppc_pkg::*;
#(
  parameter int LOW_W = 4,
  parameter int PAIRS = 6,
  localparam int CNT_W = LOW_W + PAIR_W * PAIRS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] count
);
  localparam logic [PAIRS-1:0] CHAIN_RST = PAIRS'(1);

  logic [LOW_W-1:0] low_bits;
  logic             eo_flag;
  logic [PAIRS-1:0] carry_tick;
  logic [PAIRS-1:0] full_next;
  logic [PAIRS-1:0] chain_q;
  logic [PAIRS:0]   prefix_full;

  ppc_low_stage #(.LOW_W(LOW_W)) u_low (
    .clk(clk), .rst(rst), .en(en), .low_q(low_bits), .eo_q(eo_flag)
  );

  assign count[LOW_W-1:0] = low_bits;
  assign prefix_full[0]   = 1'b1;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    logic [PAIR_W-1:0] val;
    // single AND from registered look-ahead terms
    assign carry_tick[k] = en & eo_flag & chain_q[k];
    ppc_pair_stage u_pair (
      .clk(clk), .rst(rst), .adv(carry_tick[k]),
      .val_q(val), .full_next(full_next[k])
    );
    assign count[LOW_W + PAIR_W*k +: PAIR_W] = val;
    assign prefix_full[k+1] = prefix_full[k] & full_next[k];
  end

  // chain_q[k]: every upper stage below k is full
  always_ff @(posedge clk) begin
    if (rst) chain_q <= CHAIN_RST;
    else     chain_q <= prefix_full[PAIRS-1:0];
  end
endmodule

// File: rtl/ppc_counter_chk.sv
module ppc_counter_chk #(
  parameter int LOW_W = 4,
  parameter int PAIRS = 6,
  parameter int CNT_W = LOW_W + 2 * PAIRS
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [CNT_W-1:0] count,
  input logic [LOW_W-1:0] low_bits,
  input logic             eo_flag,
  input logic [PAIRS-1:0] carry_tick
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) AST_RESET_ZERO: assert (count == '0); // R1
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    en |=> count == CNT_W'($past(count) + 1'b1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en && (&count)) |=> count == '0); // R4
  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (rst)
    (|carry_tick) |-> (en && (&low_bits))); // R5
  AST_EO_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    eo_flag == (&low_bits)); // R6
endmodule

bind ppc_counter ppc_counter_chk #(.LOW_W(LOW_W), .PAIRS(PAIRS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .count(count),
  .low_bits(low_bits), .eo_flag(eo_flag), .carry_tick(carry_tick)
);

// File: tb/ppc_counter_test.sv
module ppc_counter_test;
  localparam int LOW_W = 4;
  localparam int PAIRS = 6;
  localparam int CNT_W = LOW_W + 2 * PAIRS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] ref_cnt = '0;
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ppc_counter #(.LOW_W(LOW_W), .PAIRS(PAIRS)) uut (
    .clk(clk), .rst(rst), .en(en), .count(count)
  );

  task automatic check(input string req, input logic [CNT_W-1:0] exp);
    n_cmp++;
    if (count !== exp) begin
      n_bad++;
      $display("FAIL %s: count=%h expected=%h", req, count, exp);
    end
  endtask

  // one edge with given controls, reference updated from the requirements
  task automatic step(input logic r, input logic e, input string req);
    @(negedge clk);
    rst = r; en = e;
    @(posedge clk);
    #1;
    if (r)      ref_cnt = '0;
    else if (e) ref_cnt = ref_cnt + 1'b1;
    check(req, ref_cnt);
  endtask

  task automatic t_reset;
    step(1'b1, 1'b1, "R9 reset beats enable");
    step(1'b1, 1'b0, "R1 reset value");
    check("R1 zero after reset", '0);
    step(1'b0, 1'b1, "R1 first count");
    check("R1 first count is one", CNT_W'(1));
  endtask

  task automatic t_random(input int n);
    for (int i = 0; i < n; i++)
      step(1'b0, ($urandom_range(3) != 0), "R2/R3 random gaps");
  endtask

  task automatic t_carry_gap;
    step(1'b1, 1'b0, "R1 reset");
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1, "R2 count up");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R8 hold at low all ones");
    check("R3 held value", CNT_W'(15));
    step(1'b0, 1'b1, "R8 resume after gap");
    check("R5 carry into stage 0", CNT_W'(16));
    for (int i = 0; i < 240; i++) step(1'b0, 1'b1, "R2 count up");
    check("R7 bit position of stage 2", CNT_W'(1) << (LOW_W + 4));
  endtask

  task automatic t_wrap;
    step(1'b1, 1'b0, "R1 reset");
    for (int i = 0; i < (1 << CNT_W) - 1; i++) step(1'b0, 1'b1, "R2 long run");
    check("R4 at all ones", '1);
    step(1'b0, 1'b0, "R8 pause at all ones");
    step(1'b0, 1'b0, "R8 pause at all ones");
    step(1'b0, 1'b1, "R4 wrap to zero");
    check("R4 zero after wrap", '0);
  endtask

  task automatic t_reset_mid;
    for (int i = 0; i < 37; i++) step(1'b0, 1'b1, "R2 count up");
    step(1'b1, 1'b1, "R9 reset mid run");
    check("R9 zero", '0);
    step(1'b0, 1'b1, "R1 restart");
  endtask

  initial begin
    t_reset();
    t_random(3000);
    t_carry_gap();
    t_reset_mid();
    t_wrap();
    t_random(500);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule